// File: doc/BRIEF.md
# Power-Management Timer and Event Block

This block keeps a free-running timer and a pair of 16-bit event registers (status and enable) behind a small register bus, and drives a level interrupt line from them. The timer advances by one on every clock in which a tick-enable strobe is high; in a system this strobe runs at the power-management timer rate. Every time the timer's most significant bit changes, in either direction, the timer status flag is raised. Two further status flags are raised by single-cycle event pulses from outside: one for the power button and one for a global event. The interrupt line is high while any interrupt-capable status bit is also enabled.

Software reaches the block through two address windows. The event window is four bytes wide. It holds status at byte offsets 0 and 1 and enable at byte offsets 2 and 3. The timer window is a single dword. A bus request names an address, a size code and, for writes, a data word. A small bus sequencer walks the bytes of a write one per clock, so a wide write can cover several registers. Status bytes are write-one-to-clear and enable bytes are plain stores.

The sequencer has three states. IDLE accepts a request. WRITE applies one byte lane per cycle. READ presents the read data for one cycle. The transitions are: IDLE to WRITE on a write that starts in the event window; IDLE to READ on any read; WRITE to WRITE while bytes remain; WRITE to IDLE after the last byte; READ to IDLE always. A write outside the event window leaves the sequencer in IDLE.

Top module: `pm_event_timer`

## Requirements
- R1: After reset the timer, status and enable registers read as zero, `sci` is low and `bus_ready` is high.
- R2: The timer increments by one on each clock with `tick_en` high and holds otherwise. It is `TMR_W` bits wide (default 32) and wraps modulo 2^TMR_W.
- R3: Each change of the timer's most significant bit, whether 0 to 1 or 1 to 0, sets status bit 0.
- R4: A `pwr_evt` pulse sets status bit 5 and a `gbl_evt` pulse sets status bit 8. A set in the same cycle as a write-one-to-clear of that bit wins. All other status bits stay zero.
- R5: A read accepted in the event window returns {enable, status} shifted right by 8 times the byte offset. The result is cut to 8 bits for size code 00 and to 16 bits for size code 01; codes 10 and 11 return all 32 bits. `bus_rvalid` is high with `bus_rdata` in the cycle after acceptance.
- R6: A read at the timer address with a dword size code (10 or 11) returns the timer, zero-extended. Any other size code there returns 0, and so does a read outside both windows.
- R7: A write that starts in the event window is applied one byte per cycle. The byte `bus_wdata[8k+7:8k]` goes to byte offset start+k, with 1, 2 or 4 bytes for size codes 00, 01 and 10/11. `bus_ready` stays low for exactly that many cycles after acceptance. Offsets 0 and 1 are status bits 7:0 and 15:8; offsets 2 and 3 are enable bits 7:0 and 15:8.
- R8: A byte written to a status offset clears exactly the status bits where that byte holds a 1.
- R9: A byte written to an enable offset replaces that enable byte. The other enable byte is kept.
- R10: `sci` is high exactly when (status AND enable AND 0x0121) is nonzero. It follows every register update from the next cycle.
- R11: A byte of a write that would land past byte offset 3 is dropped, and `bus_err` is high in the cycle that byte would have been applied.
- R12: Writes to the timer window or outside both windows change no register, raise no `bus_err` and leave `bus_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer advance strobe |
| pwr_evt | input | 1 | Power-button event pulse |
| gbl_evt | input | 1 | Global event pulse |
| bus_req | input | 1 | Request, accepted when `bus_ready` is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | 00 byte, 01 word, 10/11 dword |
| bus_wdata | input | 32 | Write data, byte k at bits 8k+7:8k |
| bus_ready | output | 1 | Sequencer idle, request may be presented |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Write byte landed past the event window |
| sci | output | 1 | Level interrupt |

## Verification
The bench builds the block with `TMR_W` = 10, `ADDR_W` = 8, the event window at 0x40 and the timer at 0x48. The narrow timer makes the most significant bit rise after 512 ticks and fall at the wrap after 1024. Both toggle directions and the wrap are therefore reached many times within a short run. The window placement lets random addresses hit every event offset, the timer dword, the gap at 0x44 and writes that spill past offset 3.

// File: rtl/pmet_pkg.sv
package pmet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bus_state_t;

    localparam logic [1:0]  SZ_BYTE = 2'b00;
    localparam logic [1:0]  SZ_WORD = 2'b01;

    localparam int STS_TMR_BIT = 0;
    localparam int STS_PWR_BIT = 5;
    localparam int STS_GBL_BIT = 8;

    // Status bits allowed to raise the interrupt line.
    localparam logic [15:0] IRQ_MASK = 16'h0121;

    localparam int EVT_SPAN = 4;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        logic [2:0] n;
        if (sz == SZ_BYTE)      n = 3'd1;
        else if (sz == SZ_WORD) n = 3'd2;
        else                    n = 3'd4;
        return n;
    endfunction

    function automatic logic [31:0] trim_size(input logic [31:0] v, input logic [1:0] sz);
        logic [31:0] r;
        if (sz == SZ_BYTE)      r = {24'h0, v[7:0]};
        else if (sz == SZ_WORD) r = {16'h0, v[15:0]};
        else                    r = v;
        return r;
    endfunction

endpackage

// File: rtl/pmet_timer.sv
module pmet_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [TMR_W-1:0] count,
    output logic             msb_flip
);
    localparam int MSB = TMR_W - 1;
    localparam logic [TMR_W-1:0] STEP = TMR_W'(1);

    logic [TMR_W-1:0] count_n;

    always_comb begin
        count_n  = count + STEP;
        // flag the edge where the top bit changes, including the wrap
        msb_flip = tick_en && (count_n[MSB] != count[MSB]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (tick_en) count <= count_n;
    end
endmodule

// File: rtl/pmet_event_regs.sv
module pmet_event_regs
    import pmet_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lane_stb,
    input  logic [1:0]  lane_off,
    input  logic [7:0]  lane_byte,
    input  logic        set_tmr,
    input  logic        set_pwr,
    input  logic        set_gbl,
    output logic [15:0] sts,
    output logic [15:0] en,
    output logic        sci
);
    logic [15:0] clr_vec;
    logic [15:0] set_vec;
    logic [15:0] sts_n;
    logic [15:0] en_n;

    always_comb begin
        clr_vec = '0;
        en_n    = en;
        if (lane_stb) begin
            unique case (lane_off)
                2'd0: clr_vec[7:0]  = lane_byte;
                2'd1: clr_vec[15:8] = lane_byte;
                2'd2: en_n[7:0]     = lane_byte;
                2'd3: en_n[15:8]    = lane_byte;
                default: ;
            endcase
        end
        set_vec              = '0;
        set_vec[STS_TMR_BIT] = set_tmr;
        set_vec[STS_PWR_BIT] = set_pwr;
        set_vec[STS_GBL_BIT] = set_gbl;
        // a set in the same cycle as a clear keeps the bit
        sts_n = ((sts & ~clr_vec) | set_vec) & IRQ_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= sts_n;
            en  <= en_n;
        end
    end

    assign sci = |(sts & en & IRQ_MASK);
endmodule

// File: rtl/pmet_bus_fsm.sv
module pmet_bus_fsm
    import pmet_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]  EVT_BASE = 16'h0040,
    parameter logic [ADDR_W-1:0]  TMR_BASE = 16'h0048,
    parameter int                 TMR_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    input  logic [15:0]       sts,
    input  logic [15:0]       en,
    input  logic [TMR_W-1:0]  tmr,
    output logic              ready,
    output logic              rvalid,
    output logic [31:0]       rdata,
    output logic              err,
    output logic              lane_stb,
    output logic [1:0]        lane_off,
    output logic [7:0]        lane_byte
);
    bus_state_t  state_q, state_n;
    logic [2:0]  off_q, off_n;
    logic [2:0]  left_q, left_n;
    logic [31:0] data_q, data_n;
    logic [31:0] rdata_q, rdata_n;

    logic [ADDR_W-1:0] evt_diff;
    logic              evt_hit;
    logic              tmr_hit;
    logic [1:0]        evt_off;
    logic [31:0]       evt_word;
    logic [31:0]       read_word;

    // address decode and read mux
    always_comb begin
        evt_diff = addr - EVT_BASE;
        evt_hit  = evt_diff < ADDR_W'(EVT_SPAN);
        evt_off  = evt_diff[1:0];
        tmr_hit  = (addr == TMR_BASE);
        evt_word = {en, sts} >> {evt_off, 3'b000};
        if (evt_hit)                read_word = trim_size(evt_word, size);
        else if (tmr_hit && size[1]) read_word = 32'(tmr);
        else                        read_word = '0;
    end

    // next state and next datapath values
    always_comb begin
        state_n = state_q;
        off_n   = off_q;
        left_n  = left_q;
        data_n  = data_q;
        rdata_n = rdata_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (!we) begin
                        state_n = ST_READ;
                        rdata_n = read_word;
                    end else if (evt_hit) begin
                        state_n = ST_WRITE;
                        off_n   = {1'b0, evt_off};
                        left_n  = size_bytes(size);
                        data_n  = wdata;
                    end
                end
            end
            ST_WRITE: begin
                off_n  = off_q + 3'd1;
                left_n = left_q - 3'd1;
                data_n = {8'h00, data_q[31:8]};
                if (left_q == 3'd1) state_n = ST_IDLE;
            end
            ST_READ: begin
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q   <= '0;
            left_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            off_q   <= off_n;
            left_q  <= left_n;
            data_q  <= data_n;
            rdata_q <= rdata_n;
        end
    end

    // outputs
    always_comb begin
        ready     = (state_q == ST_IDLE);
        rvalid    = (state_q == ST_READ);
        rdata     = rdata_q;
        lane_off  = off_q[1:0];
        lane_byte = data_q[7:0];
        lane_stb  = (state_q == ST_WRITE) && !off_q[2];
        err       = (state_q == ST_WRITE) &&  off_q[2];
    end
endmodule

// File: rtl/pm_event_timer.sv
module pm_event_timer
    import pmet_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]  EVT_BASE = 16'h0040,
    parameter logic [ADDR_W-1:0]  TMR_BASE = 16'h0048,
    parameter int                 TMR_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              pwr_evt,
    input  logic              gbl_evt,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              sci
);
    logic [TMR_W-1:0] tmr_count;
    logic             tmr_flip;
    logic [15:0]      sts_q;
    logic [15:0]      en_q;
    logic             lane_stb;
    logic [1:0]       lane_off;
    logic [7:0]       lane_byte;

    pmet_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .count    (tmr_count),
        .msb_flip (tmr_flip)
    );

    pmet_event_regs u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_stb  (lane_stb),
        .lane_off  (lane_off),
        .lane_byte (lane_byte),
        .set_tmr   (tmr_flip),
        .set_pwr   (pwr_evt),
        .set_gbl   (gbl_evt),
        .sts       (sts_q),
        .en        (en_q),
        .sci       (sci)
    );

    pmet_bus_fsm #(
        .ADDR_W   (ADDR_W),
        .EVT_BASE (EVT_BASE),
        .TMR_BASE (TMR_BASE),
        .TMR_W    (TMR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .size      (bus_size),
        .wdata     (bus_wdata),
        .sts       (sts_q),
        .en        (en_q),
        .tmr       (tmr_count),
        .ready     (bus_ready),
        .rvalid    (bus_rvalid),
        .rdata     (bus_rdata),
        .err       (bus_err),
        .lane_stb  (lane_stb),
        .lane_off  (lane_off),
        .lane_byte (lane_byte)
    );
endmodule

// File: rtl/pm_event_timer_chk.sv
module pm_event_timer_chk #(
    parameter int TMR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             pwr_evt,
    input logic             gbl_evt,
    input logic [TMR_W-1:0] tmr,
    input logic [15:0]      sts,
    input logic [15:0]      en,
    input logic             lane_stb,
    input logic             bus_ready,
    input logic             bus_err,
    input logic             sci
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    // R2: timer steps by one on a tick
    p_tmr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (tmr == TMR_W'($past(tmr) + ONE)));

    // R2: timer holds without a tick
    p_tmr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(tmr));

    // R3: a change of the top timer bit leaves timer status set
    p_flip_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr[TMR_W-1] != $past(tmr[TMR_W-1])) |-> sts[0]);

    // R4: power-button pulse sets its flag
    p_pwr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_evt |=> sts[5]);

    // R4: global pulse sets its flag
    p_gbl_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gbl_evt |=> sts[8]);

    // R9: enable changes only through a lane write
    p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_stb |=> $stable(en));

    // R10: interrupt rises only after a write or a status source
    p_sci_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci) |-> $past(lane_stb || pwr_evt || gbl_evt || tick_en));

    // R11: error only while the sequencer is busy and no lane is written
    p_err_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!bus_ready && !lane_stb));
endmodule

bind pm_event_timer pm_event_timer_chk #(.TMR_W(TMR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .pwr_evt   (pwr_evt),
    .gbl_evt   (gbl_evt),
    .tmr       (tmr_count),
    .sts       (sts_q),
    .en        (en_q),
    .lane_stb  (lane_stb),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .sci       (sci)
);

// File: tb/pm_event_timer_bench.sv
module pm_event_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 10;
    localparam logic [7:0] EB = 8'h40;
    localparam logic [7:0] TB = 8'h48;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tick_en = 0, pwr_evt = 0, gbl_evt = 0;
    logic        bus_req = 0, bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [1:0]  bus_size = 0;
    logic [31:0] bus_wdata = 0;
    logic        bus_ready, bus_rvalid, bus_err, sci;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [TW-1:0] exp_tmr = '0;
    logic [15:0]   exp_sts = '0;
    logic [15:0]   exp_en  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_event_timer #(.ADDR_W(8), .EVT_BASE(EB), .TMR_BASE(TB), .TMR_W(TW)) u_pm_event_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwr_evt(pwr_evt), .gbl_evt(gbl_evt),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .sci(sci)
    );

    // reference model of the counting and set sources
    always @(posedge clk) begin
        if (rst_n) begin
            if (tick_en) begin
                logic [TW-1:0] nt;
                nt = exp_tmr + 1'b1;
                if (nt[TW-1] != exp_tmr[TW-1]) exp_sts[0] = 1'b1;
                exp_tmr = nt;
            end
            if (pwr_evt) exp_sts[5] = 1'b1;
            if (gbl_evt) exp_sts[8] = 1'b1;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a, input logic [1:0] sz);
        logic [31:0] v;
        if (a >= EB && a <= EB + 8'd3) begin
            v = {exp_en, exp_sts} >> (8 * (a - EB));
            if (sz == 2'b00) v = v & 32'hFF;
            else if (sz == 2'b01) v = v & 32'hFFFF;
        end else if (a == TB && sz[1]) v = {{(32-TW){1'b0}}, exp_tmr};
        else v = 0;
        return v;
    endfunction

    // applies a write to the model; returns whether a byte spilled
    task automatic model_write(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] wd,
                               output bit spill, output int busy);
        spill = 0; busy = 0;
        if (a >= EB && a <= EB + 8'd3) begin
            busy = nbytes(sz);
            for (int k = 0; k < nbytes(sz); k++) begin
                int o;
                logic [7:0] b;
                o = int'(a - EB) + k;
                b = wd[8*k +: 8];
                case (o)
                    0: exp_sts = exp_sts & ~{8'h00, b};
                    1: exp_sts = exp_sts & ~{b, 8'h00};
                    2: exp_en[7:0]  = b;
                    3: exp_en[15:8] = b;
                    default: spill = 1;
                endcase
            end
        end
    endtask

    task automatic do_op(input bit we, input logic [7:0] a, input logic [1:0] sz, input logic [31:0] wd,
                         input bit gbl_at_lane, output logic [31:0] rd, output bit saw_err,
                         output bit saw_rv, output int busy);
        @(negedge clk);
        bus_req = 1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        bus_req = 0;
        rd = bus_rdata; saw_rv = bus_rvalid; saw_err = bus_err; busy = 0;
        if (gbl_at_lane) gbl_evt = 1;
        while (!bus_ready) begin
            busy++;
            @(negedge clk);
            gbl_evt = 0;
            saw_err |= bus_err;
        end
    endtask

    task automatic check_sci(input string tag);
        check(tag, {31'b0, sci}, {31'b0, |(exp_sts & exp_en & 16'h0121)});
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [1:0] sz);
        logic [31:0] rd; bit e, rv; int bz;
        logic [31:0] exp;
        exp = model_read(a, sz);
        do_op(0, a, sz, 0, 0, rd, e, rv, bz);
        check({tag, " rdata"}, rd, exp);
        check({tag, " rvalid"}, {31'b0, rv}, 32'd1);
    endtask

    task automatic wr_check(input string tag, input logic [7:0] a, input logic [1:0] sz,
                            input logic [31:0] wd, input bit gbl_at_lane);
        logic [31:0] rd; bit e, rv; int bz;
        bit spill; int ebusy;
        do_op(1, a, sz, wd, gbl_at_lane, rd, e, rv, bz);
        model_write(a, sz, wd, spill, ebusy);
        if (gbl_at_lane) exp_sts[8] = 1'b1;
        check({tag, " R11 err"}, {31'b0, e}, {31'b0, spill});
        check({tag, " R7 busy"}, bz, ebusy);
    endtask

    task automatic run_ticks(input int n);
        repeat (n) begin @(negedge clk); tick_en = 1; end
        @(negedge clk); tick_en = 0;
    endtask

    task automatic idle_random(input int n);
        repeat (n) begin
            @(negedge clk);
            tick_en = $urandom % 4 != 0;
            pwr_evt = ($urandom % 32) == 0;
            gbl_evt = ($urandom % 32) == 0;
        end
        @(negedge clk);
        tick_en = 0; pwr_evt = 0; gbl_evt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", {31'b0, bus_ready}, 32'd1);
        check("R1 sci", {31'b0, sci}, 32'd0);
        rd_check("R1 event dword", EB, 2'b10);
        rd_check("R1 timer", TB, 2'b10);

        // R2, R3: rise of the top bit at 512 ticks
        run_ticks(600);
        check("R2 model count", {22'b0, exp_tmr}, 32'd600);
        rd_check("R2 timer 600", TB, 2'b10);
        rd_check("R3 status rise", EB, 2'b00);
        wr_check("R8 clear tmr sts", EB, 2'b00, 32'h01, 0);
        rd_check("R8 after clear", EB, 2'b01);
        // R2, R3: wrap at 1024, top bit falls
        run_ticks(424);
        check("R2 wrap model", {22'b0, exp_tmr}, 32'd0);
        rd_check("R2 timer wrapped", TB, 2'b10);
        rd_check("R3 status fall", EB, 2'b00);

        // R6: non-dword timer reads and unmapped reads give zero
        run_ticks(5);
        rd_check("R6 timer byte", TB, 2'b00);
        rd_check("R6 timer word", TB, 2'b01);
        rd_check("R6 unmapped", 8'h44, 2'b10);

        // R4, R10: power-button flag and interrupt
        wr_check("R8 clear all", EB, 2'b01, 32'hFFFF, 0);
        @(negedge clk); pwr_evt = 1; @(negedge clk); pwr_evt = 0;
        rd_check("R4 pwr flag", EB, 2'b00);
        check_sci("R10 not enabled");
        wr_check("R9 en low", EB + 8'd2, 2'b00, 32'h20, 0);
        check_sci("R10 enabled high");
        check("R10 sci level", {31'b0, sci}, 32'd1);
        wr_check("R8 clear pwr", EB, 2'b00, 32'h20, 0);
        check("R10 sci dropped", {31'b0, sci}, 32'd0);

        // R4: set wins over same-cycle clear of the global flag
        @(negedge clk); gbl_evt = 1; @(negedge clk); gbl_evt = 0;
        wr_check("R4 collide", EB + 8'd1, 2'b00, 32'h01, 1);
        rd_check("R4 gbl kept", EB, 2'b01);

        // R9: high enable lane kept when low written
        wr_check("R9 en high", EB + 8'd3, 2'b00, 32'hA5, 0);
        wr_check("R9 en low only", EB + 8'd2, 2'b00, 32'h3C, 0);
        rd_check("R9 en word", EB + 8'd2, 2'b01);

        // R11: word write at offset 3 spills one byte
        wr_check("R11 spill", EB + 8'd3, 2'b01, 32'hEE01, 0);
        rd_check("R11 en after spill", EB + 8'd2, 2'b01);

        // R12: timer window and unmapped writes ignored
        wr_check("R12 timer write", TB, 2'b10, 32'hFFFF_FFFF, 0);
        rd_check("R12 timer kept", TB, 2'b10);
        wr_check("R12 unmapped write", 8'h44, 2'b10, 32'hFFFF_FFFF, 0);
        rd_check("R12 event kept", EB, 2'b10);
        check("R12 ready", {31'b0, bus_ready}, 32'd1);

        // random mix: R5, R7, R8, R9, R10, R11
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [1:0] sz;
            case ($urandom % 8)
                0: a = EB; 1: a = EB + 8'd1; 2: a = EB + 8'd2; 3: a = EB + 8'd3;
                4: a = 8'h44; default: a = TB;
            endcase
            sz = 2'($urandom % 4);
            idle_random($urandom % 12);
            check_sci("R10 random");
            if ($urandom % 2) wr_check("R7 random write", a, sz, $urandom, 0);
            else              rd_check("R5 random read", a, sz);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule